// File: doc/BRIEF.md
# Store Buffer with Read Bypass

This block sits between a cache and the next memory level. It holds stores that the cache sends on (write-through stores, and the single words of a dirty line being evicted) and drains them to memory over one request/acknowledge port. A read for a cache miss does not wait behind those stores. It goes to memory ahead of any buffered store that has not yet started. If the buffer already holds data for the requested address, the read is answered from the buffer and memory is not used.

The cache evicts a dirty line by pushing its words as stores and then issuing the read miss for the new line. The read reaches memory first and the write-back follows. Stores to an address already waiting in the buffer are merged into that entry. Entries drain oldest first. A store that already sits on the memory port is never changed.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, and after a reset applied while stores are buffered, `wr_ready` and `rd_ready` are 1, `mem_req` and `rd_resp_valid` are 0, and no buffered store ever reaches memory.
- R2: Every accepted store reaches memory exactly once as a write (`mem_we`=1) with its address and latest data. Stores to distinct addresses drain in acceptance order.
- R3: The buffer holds DEPTH entries. With DEPTH distinct buffered addresses, `wr_ready` is 0 for any store that cannot merge, and that store is not taken.
- R4: A store whose address matches a buffered entry that is not on the memory port overwrites that entry's data. It is accepted even when the buffer is full and causes no extra memory write. A match against only the entry on the port is handled as a new entry.
- R5: A read whose address matches no buffered entry goes to memory (`mem_we`=0). `rd_resp_valid` pulses one cycle after the `mem_ack` of that read, with the memory data.
- R6: A read whose address matches a buffered entry gets `rd_resp_valid` in the cycle after acceptance, with the buffered data, and no memory read is issued.
- R7: When two buffered entries share the read address (the older one on the port), the newer entry's data is returned.
- R8: A store drain starts on the port only when no read miss is waiting. A store already on the port finishes before a waiting read is issued.
- R9: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged in the next cycle.
- R10: Only one read is outstanding. `rd_ready` is 0 from the acceptance of a read miss until its response.
- R11: A read and a store accepted in the same cycle: the read is compared against the entries present before that cycle, so it does not see that store.
- R12: Eviction order: a store is buffered and then a read miss to another address is accepted before the store starts. Memory then sees the read before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Store offered |
| wr_ready | output | 1 | Store accepted this cycle if valid |
| wr_addr | input | ADDR_W | Store word address |
| wr_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | Read accepted this cycle if valid |
| rd_addr | input | ADDR_W | Read word address |
| rd_resp_valid | output | 1 | One-cycle pulse: read data valid |
| rd_resp_data | output | DATA_W | Read data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data (0 on reads) |
| mem_ack | input | 1 | One-cycle acknowledge; ends the request |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` on a read |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, and for a single cycle per request. They also assume that `mem_rdata` is valid in the acknowledge cycle of a read. The bench's memory model acks each request once, after a fixed latency or after a hold flag is lowered. It drops `mem_ack` in the following cycle and returns data in the same cycle as the ack. Upstream inputs change only on falling edges, and are held until the matching ready has been seen.

// File: rtl/wbuf_pkg.sv
// Shared types for the store buffer with read bypass.
package wbuf_pkg;
    // Memory-port owner state: idle, draining a store, or serving a read miss.
    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_WR   = 2'd1,
        PORT_RD   = 2'd2
    } port_st_e;
endpackage

// File: rtl/wbuf_store.sv
// Entry storage for the store buffer: a circular FIFO of DEPTH address/data
// entries with two associative comparators. One finds a merge target for an
// incoming store. The other finds the newest entry matching a read address.
// Assumes pop is asserted only while the head is on the memory port
// (head_busy) and the buffer is non-empty.
module wbuf_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    input  logic              head_busy,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              nonempty,
    output logic [CNT_W-1:0]  fill,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);
    logic [DEPTH-1:0]  ent_v;
    logic [ADDR_W-1:0] ent_a [DEPTH];
    logic [DATA_W-1:0] ent_d [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  cnt;
    logic [DEPTH-1:0]  mrg_m, look_m;
    logic [PTR_W-1:0]  mrg_idx;
    logic              mrg_any, do_push, do_merge, do_alloc;

    // Advance a ring pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-entry comparators; the head on the port is not a merge target.
    for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
        assign mrg_m[j]  = ent_v[j] && (ent_a[j] == push_addr)
                           && !(head_busy && (rd_ptr == PTR_W'(j)));
        assign look_m[j] = ent_v[j] && (ent_a[j] == look_addr);
    end

    // Pick the (at most one) merge target.
    always_comb begin
        mrg_idx = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (mrg_m[j]) mrg_idx = PTR_W'(j);
        end
    end

    // Walk entries from oldest to newest; the last match is the newest.
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int k;
            k = (int'(rd_ptr) + i) % DEPTH;
            if (look_m[PTR_W'(k)]) begin
                look_hit  = 1'b1;
                look_data = ent_d[PTR_W'(k)];
            end
        end
    end

    assign mrg_any    = |mrg_m;
    assign push_ready = mrg_any || (cnt < CNT_W'(DEPTH));
    assign do_push    = push_valid && push_ready;
    assign do_merge   = do_push && mrg_any;
    assign do_alloc   = do_push && !mrg_any;
    assign head_addr  = ent_a[rd_ptr];
    assign head_data  = ent_d[rd_ptr];
    assign nonempty   = (cnt != '0);
    assign fill       = cnt;

    // Valid bits, ring pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_alloc) begin
                ent_v[wr_ptr] <= 1'b1;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                ent_v[rd_ptr] <= 1'b0;
                rd_ptr        <= bump(rd_ptr);
            end
            cnt <= cnt + CNT_W'(do_alloc) - CNT_W'(pop);
        end
    end

    // Entry address/data payload; no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (do_alloc) begin
            ent_a[wr_ptr] <= push_addr;
            ent_d[wr_ptr] <= push_data;
        end
        if (do_merge) begin
            ent_d[mrg_idx] <= push_data;
        end
    end
endmodule

// File: rtl/wbuf_port.sv
// Memory-port arbiter. It owns the single request/acknowledge port. From
// idle it serves a waiting read miss first, otherwise it starts draining the
// head store. A started transfer runs until acknowledged, with address and
// data held. Assumes mem_ack is a one-cycle pulse that comes only during a
// request.
module wbuf_port
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_pend,
    input  logic [ADDR_W-1:0] rd_addr_q,
    input  logic              nonempty,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              head_busy,
    output logic              pop,
    output logic              rd_done
);
    port_st_e st;

    // Port state: reads win from idle; transfers end on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PORT_IDLE;
        end else begin
            case (st)
                PORT_IDLE: begin
                    if (rd_pend)       st <= PORT_RD;
                    else if (nonempty) st <= PORT_WR;
                end
                PORT_WR:   if (mem_ack) st <= PORT_IDLE;
                PORT_RD:   if (mem_ack) st <= PORT_IDLE;
                default:   st <= PORT_IDLE;
            endcase
        end
    end

    // Port outputs and completion strobes decoded from the state.
    always_comb begin
        mem_req   = (st != PORT_IDLE);
        mem_we    = (st == PORT_WR);
        mem_addr  = (st == PORT_RD) ? rd_addr_q : head_addr;
        mem_wdata = (st == PORT_WR) ? head_data : '0;
        head_busy = (st == PORT_WR);
        pop       = (st == PORT_WR) && mem_ack;
        rd_done   = (st == PORT_RD) && mem_ack;
    end
endmodule

// File: rtl/wbuf_rdctl.sv
// Read-miss control. It accepts one read at a time. A buffer match is
// answered in the next cycle from the buffer. Otherwise the read is left
// pending for the port arbiter, and the memory data is returned the cycle
// after acknowledge. Assumes look_hit/look_data reflect rd_addr in the
// same cycle.
module wbuf_rdctl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    input  logic              look_hit,
    input  logic [DATA_W-1:0] look_data,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_pend,
    output logic [ADDR_W-1:0] rd_addr_q,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data
);
    logic accept;

    assign rd_ready = !rd_pend;
    assign accept   = rd_valid && rd_ready;

    // Accept, forward or park a read; return memory data on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend       <= 1'b0;
            rd_addr_q     <= '0;
            rd_resp_valid <= 1'b0;
            rd_resp_data  <= '0;
        end else begin
            rd_resp_valid <= 1'b0;
            if (accept) begin
                if (look_hit) begin
                    rd_resp_valid <= 1'b1;
                    rd_resp_data  <= look_data;
                end else begin
                    rd_pend   <= 1'b1;
                    rd_addr_q <= rd_addr;
                end
            end else if (rd_done) begin
                rd_pend       <= 1'b0;
                rd_resp_valid <= 1'b1;
                rd_resp_data  <= mem_rdata;
            end
        end
    end
endmodule

// File: rtl/wbuf_bypass.sv
// Store buffer with read bypass (top). It joins entry storage, read-miss
// control and the memory-port arbiter. Stores are buffered and drained in
// order. Read misses overtake undrained stores, or are answered from the
// buffer on an address match. Assumes one word per address and
// upstream/downstream handshakes as described in the brief.
module wbuf_bypass #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              head_busy_w, pop_w, nonempty_w, look_hit_w;
    logic              rd_pend_w, rd_done_w;
    logic [ADDR_W-1:0] head_addr_w, rd_addr_q_w;
    logic [DATA_W-1:0] head_data_w, look_data_w;
    logic [CNT_W-1:0]  fill_w;

    wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (wr_valid),
        .push_addr  (wr_addr),
        .push_data  (wr_data),
        .push_ready (wr_ready),
        .head_busy  (head_busy_w),
        .pop        (pop_w),
        .head_addr  (head_addr_w),
        .head_data  (head_data_w),
        .nonempty   (nonempty_w),
        .fill       (fill_w),
        .look_addr  (rd_addr),
        .look_hit   (look_hit_w),
        .look_data  (look_data_w)
    );

    wbuf_rdctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_valid      (rd_valid),
        .rd_addr       (rd_addr),
        .rd_ready      (rd_ready),
        .look_hit      (look_hit_w),
        .look_data     (look_data_w),
        .rd_done       (rd_done_w),
        .mem_rdata     (mem_rdata),
        .rd_pend       (rd_pend_w),
        .rd_addr_q     (rd_addr_q_w),
        .rd_resp_valid (rd_resp_valid),
        .rd_resp_data  (rd_resp_data)
    );

    wbuf_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pend   (rd_pend_w),
        .rd_addr_q (rd_addr_q_w),
        .nonempty  (nonempty_w),
        .head_addr (head_addr_w),
        .head_data (head_data_w),
        .mem_ack   (mem_ack),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .head_busy (head_busy_w),
        .pop       (pop_w),
        .rd_done   (rd_done_w)
    );
endmodule

// File: rtl/wbuf_bypass_chk.sv
// Property checker for wbuf_bypass, attached by bind. It assumes mem_ack
// is a one-cycle pulse inside a request, with read data valid alongside.
module wbuf_bypass_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ready,
    input logic              rd_ready,
    input logic              rd_resp_valid,
    input logic [DATA_W-1:0] rd_resp_data,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [CNT_W-1:0]  fill,
    input logic              rd_pend
);
    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    a_r3_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (fill == CNT_W'(DEPTH)));

    a_r5_resp_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=>
            (rd_resp_valid && (rd_resp_data == $past(mem_rdata))));

    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !rd_ready);

    a_r8_drain_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_we) |-> !$past(rd_pend));
endmodule

bind wbuf_bypass wbuf_bypass_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ready      (wr_ready),
    .rd_ready      (rd_ready),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_data  (rd_resp_data),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .fill          (fill_w),
    .rd_pend       (rd_pend_w)
);

// File: tb/tb_wbuf_bypass.sv
module tb_wbuf_bypass;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int MEM_LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_rst = 1'b1;
    logic          wr_valid = 1'b0, rd_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_ready, rd_ready, rd_resp_valid;
    logic [DW-1:0] rd_resp_data;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wbuf_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Behavioural memory with latency, a hold flag and a transaction log.
    logic [DW-1:0] mem [256];
    logic          written [256];
    logic          log_we [256];
    logic [AW-1:0] log_a [256];
    logic [DW-1:0] log_d [256];
    int            log_n;
    int            lat_cnt;
    logic          mem_hold = 1'b0;

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return 32'h1000_0000 | {24'h0, a};
    endfunction

    always @(posedge clk) begin
        if (mem_rst) begin
            for (int i = 0; i < 256; i++) written[i] <= 1'b0;
            mem_ack <= 1'b0; lat_cnt <= 0; log_n <= 0; mem_rdata <= '0;
        end else if (!rst_n || mem_ack) begin
            mem_ack <= 1'b0; lat_cnt <= 0;
        end else if (mem_req && !mem_hold) begin
            if (lat_cnt == MEM_LAT) begin
                mem_ack <= 1'b1; lat_cnt <= 0;
                log_we[log_n] <= mem_we; log_a[log_n] <= mem_addr;
                log_d[log_n] <= mem_we ? mem_wdata : '0;
                log_n <= log_n + 1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata; written[mem_addr] <= 1'b1;
                end else begin
                    mem_rdata <= written[mem_addr] ? mem[mem_addr] : init_val(mem_addr);
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    function automatic logic [DW-1:0] mem_now(input logic [AW-1:0] a);
        return written[a] ? mem[a] : init_val(a);
    endfunction

    int errors = 0;
    int checks = 0;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        while (!rd_ready) @(negedge clk);
        @(negedge clk);
        rd_valid = 1'b0; lat = 0;
        while (!rd_resp_valid) begin @(negedge clk); lat++; end
        d = rd_resp_data;
    endtask

    // Read and store offered in the same cycle; both expected ready.
    task automatic do_both(input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                           input logic [DW-1:0] wd, output logic [DW-1:0] d, output int lat);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = ra; wr_valid = 1'b1; wr_addr = wa; wr_data = wd;
        #1;
        chk("R11 both ready", {30'd0, rd_ready, wr_ready}, 32'd3);
        @(negedge clk);
        rd_valid = 1'b0; wr_valid = 1'b0; lat = 0;
        while (!rd_resp_valid) begin @(negedge clk); lat++; end
        d = rd_resp_data;
    endtask

    task automatic drain();
        repeat (60) @(negedge clk);
    endtask

    task automatic chk_log(input int idx, input logic we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string req);
        chk(req, {log_d[idx][DW-10:0], log_we[idx], log_a[idx]}, {d[DW-10:0], we, a});
    endtask

    typedef struct packed {
        logic          is_rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b0, 8'h10, 32'hAAAA_0001},
        '{1'b0, 8'h11, 32'hAAAA_0002},
        '{1'b1, 8'h10, 32'hAAAA_0001},
        '{1'b1, 8'h20, 32'h1000_0020},
        '{1'b0, 8'h10, 32'hBBBB_0001},
        '{1'b1, 8'h10, 32'hBBBB_0001},
        '{1'b1, 8'h11, 32'hAAAA_0002},
        '{1'b0, 8'h30, 32'hCCCC_0030},
        '{1'b0, 8'h31, 32'hCCCC_0031},
        '{1'b0, 8'h32, 32'hCCCC_0032},
        '{1'b0, 8'h33, 32'hCCCC_0033},
        '{1'b0, 8'h34, 32'hCCCC_0034},
        '{1'b1, 8'h33, 32'hCCCC_0033},
        '{1'b1, 8'h40, 32'h1000_0040}
    };

    logic [DW-1:0] shadow [256];
    logic          sh_set [256];

    initial begin
        fork
            begin : tests
                logic [DW-1:0] d;
                int lat, base;
                for (int i = 0; i < 256; i++) sh_set[i] = 1'b0;
                repeat (3) @(negedge clk);
                mem_rst = 1'b0;
                repeat (2) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1: reset state
                chk("R1 reset ready/idle", {28'd0, wr_ready, rd_ready, mem_req, rd_resp_valid},
                    {28'd0, 4'b1100});

                // Vector table: R2/R5/R6 data path under mixed traffic
                for (int v = 0; v < 14; v++) begin
                    if (VECS[v].is_rd) begin
                        do_read(VECS[v].addr, d, lat);
                        chk("R5/R6 table read data", d, VECS[v].data);
                    end else begin
                        do_write(VECS[v].addr, VECS[v].data);
                        shadow[VECS[v].addr] = VECS[v].data;
                        sh_set[VECS[v].addr] = 1'b1;
                    end
                end
                drain();
                for (int a = 0; a < 256; a++) begin
                    if (sh_set[a]) chk("R2 final memory contents", mem_now(AW'(a)), shadow[a]);
                end

                // R5/R8/R10/R12: read miss overtakes undrained stores
                mem_hold = 1'b1;
                base = log_n;
                do_write(8'h50, 32'h5000_0001);
                do_write(8'h51, 32'h5100_0001);
                do_write(8'h52, 32'h5200_0001);
                fork
                    do_read(8'h60, d, lat);
                    begin
                        repeat (4) @(negedge clk);
                        chk("R10 rd_ready low during miss", {31'd0, rd_ready}, 32'd0);
                        mem_hold = 1'b0;
                    end
                join
                chk("R5 miss data from memory", d, init_val(8'h60));
                drain();
                chk("R2 log length", log_n - base, 4);
                chk_log(base + 0, 1'b1, 8'h50, 32'h5000_0001, "R8 started store finishes first");
                chk_log(base + 1, 1'b0, 8'h60, 32'h0, "R12 read before queued stores");
                chk_log(base + 2, 1'b1, 8'h51, 32'h5100_0001, "R2 fifo order");
                chk_log(base + 3, 1'b1, 8'h52, 32'h5200_0001, "R2 fifo order");
                chk("R10 rd_ready after response", {31'd0, rd_ready}, 32'd1);

                // R3/R4/R9: full buffer, stall and merge
                mem_hold = 1'b1;
                base = log_n;
                do_write(8'h70, 32'h7000_0000);
                do_write(8'h71, 32'h7000_0001);
                do_write(8'h72, 32'h7000_0002);
                do_write(8'h73, 32'h7000_0003);
                @(negedge clk);
                chk("R9 held request", {mem_addr, 23'd0, mem_we}, {8'h70, 23'd0, 1'b1});
                wr_valid = 1'b1; wr_addr = 8'h74; wr_data = 32'h7400_0000;
                #1;
                chk("R3 full stalls new address", {31'd0, wr_ready}, 32'd0);
                @(negedge clk);
                chk("R9 held request", {mem_addr, 23'd0, mem_req}, {8'h70, 23'd0, 1'b1});
                wr_addr = 8'h70;
                #1;
                chk("R4 no merge into entry on port", {31'd0, wr_ready}, 32'd0);
                @(negedge clk);
                wr_valid = 1'b0;
                do_write(8'h72, 32'h7200_00FF);
                mem_hold = 1'b0;
                drain();
                chk("R3 stalled store not taken", log_n - base, 4);
                chk_log(base + 0, 1'b1, 8'h70, 32'h7000_0000, "R2 fifo order");
                chk_log(base + 1, 1'b1, 8'h71, 32'h7000_0001, "R2 fifo order");
                chk_log(base + 2, 1'b1, 8'h72, 32'h7200_00FF, "R4 merged in place");
                chk_log(base + 3, 1'b1, 8'h73, 32'h7000_0003, "R2 fifo order");

                // R6/R7: newest of two matching entries is forwarded
                mem_hold = 1'b1;
                base = log_n;
                do_write(8'h80, 32'h8000_0001);
                repeat (2) @(negedge clk);
                do_write(8'h80, 32'h8000_0002);
                do_read(8'h80, d, lat);
                chk("R7 newest match forwarded", d, 32'h8000_0002);
                chk("R6 hit answered next cycle", lat, 0);
                mem_hold = 1'b0;
                drain();
                chk("R6 no memory read on hit", log_n - base, 2);
                chk_log(base + 1, 1'b1, 8'h80, 32'h8000_0002, "R4 match on port allocates");
                chk("R2 final value", mem_now(8'h80), 32'h8000_0002);

                // R11: same-cycle read and store
                do_both(8'h90, 8'h90, 32'h9000_0001, d, lat);
                chk("R11 read misses same-cycle store", d, init_val(8'h90));
                drain();
                chk("R2 store after read", mem_now(8'h90), 32'h9000_0001);
                mem_hold = 1'b1;
                do_write(8'hA0, 32'hA000_0001);
                repeat (2) @(negedge clk);
                do_write(8'hA1, 32'hA100_0001);
                do_both(8'hA1, 8'hA1, 32'hA100_00FF, d, lat);
                chk("R11 read sees pre-merge data", d, 32'hA100_0001);
                mem_hold = 1'b0;
                drain();
                chk("R4 merged value reaches memory", mem_now(8'hA1), 32'hA100_00FF);

                // R1: reset drops buffered stores
                mem_hold = 1'b1;
                do_write(8'hB0, 32'hB000_0001);
                do_write(8'hB1, 32'hB100_0001);
                rst_n = 1'b0;
                repeat (2) @(negedge clk);
                rst_n = 1'b1;
                base = log_n;
                @(negedge clk);
                chk("R1 idle after reset", {28'd0, wr_ready, rd_ready, mem_req, rd_resp_valid},
                    {28'd0, 4'b1100});
                mem_hold = 1'b0;
                drain();
                chk("R1 no stale store drained", log_n - base, 0);
            end
            begin : watchdog
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule